// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside a receive path that delivers frame bytes eight bits at a time, qualified by a data-valid signal. While the first six bytes of a frame go past, it compares them, one per cycle, with every address it is allowed to accept. These are a programmable unicast address, the all-ones broadcast address, a configured pause address, the fixed pause multicast address 01-80-C2-00-00-01, and up to four valid entries of a small address table. When data-valid falls, the block issues a one-cycle pass or drop strobe for the frame just ended.

A promiscuous flag is set out of reset and makes every frame pass. Software programs the block through a single write port with a 3-bit select. Table entries are written in two steps: a data word stages the low 32 address bits, then a command word supplies the high 16 bits, the entry location and a read flag. A read command returns the chosen entry on a read-data port over two consecutive cycles, low word first. CRC checking and frame storage belong to other blocks.

The match state machine has three states. `MS_IDLE` waits for data-valid. `MS_DEST` compares the six destination bytes. `MS_BODY` waits for the end of the frame. Its transitions are:
- start (`MS_IDLE` to `MS_DEST` on data-valid)
- address done (`MS_DEST` to `MS_BODY` after the sixth byte)
- short end (`MS_DEST` to `MS_IDLE` when data-valid falls early)
- frame end (`MS_BODY` to `MS_IDLE` when data-valid falls)

The table read sequencer steps `RD_IDLE` to `RD_LOW` on a read command, then `RD_LOW` to `RD_HIGH`, then `RD_HIGH` back to `RD_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: A 48-bit address is held with the first received byte in bits 7:0 and the sixth in bits 47:40 (AA-BB-CC-DD-EE-FF is 48'hFFEEDDCCBBAA). Destination byte k is compared with bits 8k+7:8k, so the same six bytes in reverse order do not match.
- R2: With promiscuous mode off, a frame whose destination equals the unicast address passes.
- R3: With promiscuous mode off, a frame whose destination is FF-FF-FF-FF-FF-FF passes.
- R4: With promiscuous mode off, a frame passes if its destination equals the `pause_addr` input or 01-80-C2-00-00-01.
- R5: With promiscuous mode off, a frame passes if its destination equals a table entry whose valid bit is set. All valid bits are clear after reset, so an all-zero destination is dropped before any table write.
- R6: With promiscuous mode off, a frame is dropped if it matches no source, or if it ends before six bytes have arrived, even when those bytes match.
- R7: Promiscuous mode is bit 31 of the mode word (select 4) and is 1 after reset. While it is 1, every frame passes, short frames included.
- R8: One cycle after the first clock edge at which data-valid is sampled low after a frame, exactly one of `frame_pass` and `frame_drop` is high, for one cycle only. Both are low after reset.
- R9: Select 2 stages address bits 31:0. Select 3 is the command word, with address bits 47:32 in 15:0, location in 17:16 and read flag in 23. With the read flag at 0, the command writes the staged 48-bit address to that location and sets its valid bit.
- R10: A command with the read flag at 1 makes `rd_valid` high for two cycles, starting the cycle after the write. The first cycle carries address bits 31:0 of the entry and the second carries {16'h0, bits 47:32}.
- R11: The unicast address is loaded from `uni_default` at reset. Select 0 replaces bits 31:0 and select 1 replaces bits 47:32 from data bits 15:0.
- R12: When the block is built without the table (`TABLE_EN` = 0), table reads still pulse `rd_valid` but return 0, and table writes never make a frame pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | High while frame bytes are delivered |
| uni_default | input | 48 | Reset value of the unicast address |
| pause_addr | input | 48 | Configured pause address accepted as destination |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Word select: 0 unicast low, 1 unicast high, 2 table data, 3 table command, 4 mode |
| cfg_wdata | input | 32 | Configuration write data |
| rd_data | output | 32 | Table read data |
| rd_valid | output | 1 | Table read data valid |
| frame_pass | output | 1 | One-cycle strobe: frame is passed to the client |
| frame_drop | output | 1 | One-cycle strobe: frame is dropped |

## Verification
The assertions take for granted two things about the inputs. Data-valid stays low for at least one cycle between frames. A table read command is not issued while a previous read is still returning its two words. The directed stimulus keeps both rules: each frame task leaves data-valid low for two cycles, and each read task waits until `rd_valid` has dropped before it returns. Configuration writes happen only while no frame is in flight, so every decision sees settled addresses.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int ADDR_W = 48;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_DEST,
        MS_BODY
    } match_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOW,
        RD_HIGH
    } rd_state_e;

    localparam logic [2:0] SEL_UNI_LO   = 3'd0;
    localparam logic [2:0] SEL_UNI_HI   = 3'd1;
    localparam logic [2:0] SEL_TBL_DATA = 3'd2;
    localparam logic [2:0] SEL_TBL_CMD  = 3'd3;
    localparam logic [2:0] SEL_MODE     = 3'd4;

    localparam logic [ADDR_W-1:0] BCAST_ADDR    = 48'hFFFF_FFFF_FFFF;
    localparam logic [ADDR_W-1:0] PAUSE_MC_ADDR = 48'h0100_00C2_8001;

    // byte k of a destination lives in bits 8k+7:8k
    function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a, input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0:    b = a[7:0];
            3'd1:    b = a[15:8];
            3'd2:    b = a[23:16];
            3'd3:    b = a[31:24];
            3'd4:    b = a[39:32];
            3'd5:    b = a[47:40];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rxaf_table.sv
module rxaf_table
    import rxaf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter bit TABLE_EN    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_sel,
    input  logic [31:0]                   wr_data,
    output logic [NUM_ENTRIES*ADDR_W-1:0] ent_addr,
    output logic [NUM_ENTRIES-1:0]        ent_vld,
    output logic [31:0]                   rd_data,
    output logic                          rd_valid
);
    localparam int LOC_W = 2;

    logic             cmd_wr;
    logic             cmd_rd;
    logic [LOC_W-1:0] cmd_loc;
    rd_state_e        rd_state;
    logic [LOC_W-1:0] rd_loc;
    logic [ADDR_W-1:0] sel_entry;

    assign cmd_wr  = wr_en && (wr_sel == SEL_TBL_CMD);
    assign cmd_rd  = wr_data[23];
    assign cmd_loc = wr_data[17:16];

    // state register of the read sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state <= RD_IDLE;
            rd_loc   <= '0;
        end else begin
            unique case (rd_state)
                RD_IDLE: if (cmd_wr && cmd_rd) begin
                    rd_state <= RD_LOW;
                    rd_loc   <= cmd_loc;
                end
                RD_LOW:  rd_state <= RD_HIGH;
                RD_HIGH: rd_state <= RD_IDLE;
                default: rd_state <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        sel_entry = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (rd_loc == LOC_W'(i)) sel_entry = ent_addr[i*ADDR_W +: ADDR_W];
        end
    end

    // outputs of the read sequencer
    always_comb begin
        unique case (rd_state)
            RD_LOW: begin
                rd_valid = 1'b1;
                rd_data  = sel_entry[31:0];
            end
            RD_HIGH: begin
                rd_valid = 1'b1;
                rd_data  = {16'h0000, sel_entry[47:32]};
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    // R10: a read command yields two data cycles, then the port goes quiet
    assert_rd_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_rd && rd_state == RD_IDLE) |=> rd_valid);
    assert_rd_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |=> !rd_valid);

    generate
        if (TABLE_EN) begin : g_table
            logic [31:0] staged_lo;

            always_ff @(posedge clk) begin
                if (!rst_n) staged_lo <= '0;
                else if (wr_en && wr_sel == SEL_TBL_DATA) staged_lo <= wr_data;
            end

            for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ent_addr[g*ADDR_W +: ADDR_W] <= '0;
                        ent_vld[g]                   <= 1'b0;
                    end else if (cmd_wr && !cmd_rd && cmd_loc == LOC_W'(g)) begin
                        ent_addr[g*ADDR_W +: ADDR_W] <= {wr_data[15:0], staged_lo};
                        ent_vld[g]                   <= 1'b1;
                    end
                end

                // R9: a write command marks its location valid
                assert_wr_sets_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd_wr && !cmd_rd && cmd_loc == LOC_W'(g)) |=> ent_vld[g]);
            end
        end else begin : g_no_table
            assign ent_addr = '0;
            assign ent_vld  = '0;
        end
    endgenerate

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    rx_data,
    input  logic                          rx_valid,
    input  logic [ADDR_W-1:0]             uni_addr,
    input  logic [ADDR_W-1:0]             pause_addr,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_addr,
    input  logic [NUM_ENTRIES-1:0]        ent_vld,
    input  logic                          prom,
    output logic                          frame_pass,
    output logic                          frame_drop
);
    localparam int FIXED_SRC = 4;
    localparam int NSRC      = FIXED_SRC + NUM_ENTRIES;
    localparam logic [2:0] LAST_DEST_BYTE = 3'd5;

    match_state_e      state;
    logic [2:0]        cnt;
    logic [NSRC-1:0]   ok;
    logic [NSRC-1:0]   byte_hit;
    logic [NSRC-1:0]   cand_en;
    logic [ADDR_W-1:0] cand [NSRC];

    always_comb begin
        cand[0] = uni_addr;
        cand[1] = BCAST_ADDR;
        cand[2] = pause_addr;
        cand[3] = PAUSE_MC_ADDR;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            cand[FIXED_SRC+i] = ent_addr[i*ADDR_W +: ADDR_W];
        end
        cand_en = {ent_vld, {FIXED_SRC{1'b1}}};
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign byte_hit[s] = cand_en[s] && (rx_data == pick_byte(cand[s], cnt));
        end
    endgenerate

    // state register: walk the destination bytes, narrowing the candidates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MS_IDLE;
            cnt   <= '0;
            ok    <= '0;
        end else begin
            unique case (state)
                MS_IDLE: if (rx_valid) begin
                    ok    <= byte_hit;
                    cnt   <= 3'd1;
                    state <= MS_DEST;
                end
                MS_DEST: begin
                    if (!rx_valid) begin
                        cnt   <= '0;
                        state <= MS_IDLE;
                    end else begin
                        ok  <= ok & byte_hit;
                        cnt <= cnt + 3'd1;
                        if (cnt == LAST_DEST_BYTE) state <= MS_BODY;
                    end
                end
                MS_BODY: if (!rx_valid) begin
                    cnt   <= '0;
                    state <= MS_IDLE;
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    // outputs: one decision strobe when the frame ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_pass <= 1'b0;
            frame_drop <= 1'b0;
        end else if (state != MS_IDLE && !rx_valid) begin
            frame_pass <= prom || (state == MS_BODY && |ok);
            frame_drop <= !(prom || (state == MS_BODY && |ok));
        end else begin
            frame_pass <= 1'b0;
            frame_drop <= 1'b0;
        end
    end

    assert_single_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_pass && frame_drop));
    assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pass || frame_drop) |=> !(frame_pass || frame_drop));
    assert_prom_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !$past(prom));
    assert_short_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pass |-> ($past(prom) || $past(state) == MS_BODY));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter bit TABLE_EN    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic [47:0] uni_default,
    input  logic [47:0] pause_addr,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        frame_pass,
    output logic        frame_drop
);
    logic [ADDR_W-1:0]             uni_addr;
    logic                          prom;
    logic [NUM_ENTRIES*ADDR_W-1:0] ent_addr;
    logic [NUM_ENTRIES-1:0]        ent_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uni_addr <= uni_default;
            prom     <= 1'b1;
        end else if (cfg_wr) begin
            if (cfg_sel == SEL_UNI_LO) uni_addr[31:0]  <= cfg_wdata;
            if (cfg_sel == SEL_UNI_HI) uni_addr[47:32] <= cfg_wdata[15:0];
            if (cfg_sel == SEL_MODE)   prom            <= cfg_wdata[31];
        end
    end

    // R11: the unicast address only moves on its own two selects
    assert_uni_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (cfg_sel == SEL_UNI_LO || cfg_sel == SEL_UNI_HI)) |=> $stable(uni_addr));

    rxaf_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .TABLE_EN    (TABLE_EN)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .ent_addr (ent_addr),
        .ent_vld  (ent_vld),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    rxaf_match #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .uni_addr   (uni_addr),
        .pause_addr (pause_addr),
        .ent_addr   (ent_addr),
        .ent_vld    (ent_vld),
        .prom       (prom),
        .frame_pass (frame_pass),
        .frame_drop (frame_drop)
    );

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic [47:0] uni_default = 48'h6655_4433_2211;
    logic [47:0] pause_addr  = 48'h0A09_0807_0605;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_data, nt_rd_data;
    logic        rd_valid, nt_rd_valid;
    logic        pass, drop, nt_pass, nt_drop;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .uni_default(uni_default), .pause_addr(pause_addr),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .frame_pass(pass), .frame_drop(drop)
    );

    rx_addr_filter #(.TABLE_EN(1'b0)) uut_nt (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .uni_default(uni_default), .pause_addr(pause_addr),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_data(nt_rd_data), .rd_valid(nt_rd_valid),
        .frame_pass(nt_pass), .frame_drop(nt_drop)
    );

    task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic send_frame(input logic [47:0] dst, input int nbytes,
                              input bit exp_pass, input bit exp_nt, input string req);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = (i < 6) ? dst[8*i +: 8] : 8'(i * 7 + 3);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_data = '0;
        @(negedge clk);
        check(pass == exp_pass && drop == !exp_pass, req, {pass, drop}, {exp_pass, !exp_pass});
        check(nt_pass == exp_nt && nt_drop == !exp_nt, {req, " (no table)"}, {nt_pass, nt_drop}, {exp_nt, !exp_nt});
        @(negedge clk);
        check(!pass && !drop && !nt_pass && !nt_drop, "R8 strobe lasts one cycle",
              {nt_pass, nt_drop, pass, drop}, 0);
    endtask

    task automatic read_entry(input logic [1:0] loc, input logic [31:0] exp_lo, input logic [31:0] exp_hi);
        host_write(3'd3, {8'h00, 1'b1, 5'b0, loc, 16'h0000});
        check(rd_valid && rd_data == exp_lo, "R10 read low word", {rd_valid, rd_data}, {1'b1, exp_lo});
        check(nt_rd_valid && nt_rd_data == 0, "R12 absent table reads 0 (low)", {nt_rd_valid, nt_rd_data}, {1'b1, 32'h0});
        @(negedge clk);
        check(rd_valid && rd_data == exp_hi, "R10 read high word", {rd_valid, rd_data}, {1'b1, exp_hi});
        check(nt_rd_valid && nt_rd_data == 0, "R12 absent table reads 0 (high)", {nt_rd_valid, nt_rd_data}, {1'b1, 32'h0});
        @(negedge clk);
        check(!rd_valid && !nt_rd_valid, "R10 read ends after two words", {rd_valid, nt_rd_valid}, 0);
    endtask

    task automatic t_reset;
        check(!pass && !drop && !rd_valid, "R8 reset outputs idle", {pass, drop, rd_valid}, 0);
    endtask

    task automatic t_promiscuous;
        send_frame(48'hC0FF_EE12_3457, 14, 1'b1, 1'b1, "R7 promiscuous default passes any frame");
        send_frame(48'h0000_0000_0BAD, 3, 1'b1, 1'b1, "R7 promiscuous passes short frame");
        host_write(3'd4, 32'h0000_0000);
        send_frame(48'hC0FF_EE12_3457, 14, 1'b0, 1'b0, "R6 unknown address dropped once promiscuous off");
    endtask

    task automatic t_unicast;
        send_frame(48'h6655_4433_2211, 10, 1'b1, 1'b1, "R11 R2 reset unicast from tie-off passes");
        send_frame(48'h1122_3344_5566, 10, 1'b0, 1'b0, "R1 reversed byte order dropped");
        host_write(3'd0, 32'hDDCC_BBAA);
        host_write(3'd1, 32'hFFFF_FFEE);
        send_frame(48'hFFEE_DDCC_BBAA, 9, 1'b1, 1'b1, "R11 reprogrammed unicast passes");
        send_frame(48'h6655_4433_2211, 9, 1'b0, 1'b0, "R11 old unicast dropped");
    endtask

    task automatic t_special;
        send_frame(48'hFFFF_FFFF_FFFF, 8, 1'b1, 1'b1, "R3 broadcast passes");
        send_frame(48'h0A09_0807_0605, 8, 1'b1, 1'b1, "R4 configured pause address passes");
        send_frame(48'h0100_00C2_8001, 8, 1'b1, 1'b1, "R4 pause multicast passes");
        send_frame(48'h0200_00C2_8001, 8, 1'b0, 1'b0, "R6 last byte differs dropped");
    endtask

    task automatic t_table;
        send_frame(48'h0000_0000_0000, 8, 1'b0, 1'b0, "R5 cleared entries never match");
        send_frame(48'h1234_5678_9ABC, 8, 1'b0, 1'b0, "R5 address before write dropped");
        host_write(3'd2, 32'h5678_9ABC);
        host_write(3'd3, {8'h00, 1'b0, 5'b0, 2'd2, 16'h1234});
        send_frame(48'h1234_5678_9ABC, 8, 1'b1, 1'b0, "R9 R5 written entry passes");
        read_entry(2'd2, 32'h5678_9ABC, 32'h0000_1234);
        read_entry(2'd0, 32'h0000_0000, 32'h0000_0000);
        send_frame(48'h0000_0000_0000, 8, 1'b0, 1'b0, "R5 unwritten location still invalid");
    endtask

    task automatic t_length;
        send_frame(48'hFFEE_DDCC_BBAA, 5, 1'b0, 1'b0, "R6 five matching bytes dropped");
        send_frame(48'hFFEE_DDCC_BBAA, 6, 1'b1, 1'b1, "R8 six-byte frame decided");
        send_frame(48'hFFEE_DDCC_BBAA, 40, 1'b1, 1'b1, "R8 long frame decided at end");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_promiscuous();
        t_unicast();
        t_special();
        t_table();
        t_length();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule